// File: doc/BRIEF.md
# Data-Space Address Generator with Pointer and Stack Registers

This block forms every data-space address that a small 8-bit processor core uses for loads, stores and stack traffic. It holds three 16-bit pointers (X, Y and Z) and an 8-bit stack pointer. When the core issues a data access, the block does four things: it selects a pointer or takes a direct address, applies the addressing mode, writes the modified pointer back, and presents the resulting address on a registered output for the memories.

The block also classifies each address it issues. The low 32 bytes overlay the working registers. The next 64 bytes overlay the I/O registers, at the I/O address plus 0x20. 128 bytes of SRAM follow, and anything above that is out of range.

The pointers live in register pairs 26/27 (X), 28/29 (Y) and 30/31 (Z), with the low byte in the even register. The register file loads them through a 16-bit host write port. The I/O space can load the stack pointer through its own write port. Z is also visible on its own output, where it serves as the byte address for constant reads from program memory into register 0. Push and pop adjust the stack pointer. Each address goes out one cycle after the request, so the memory side finishes a stack operation in two cycles.

Top module: `dspace_agu`

## Requirements
- R1: While reset is held and in the first cycle after it, `acc_valid` and `acc_err` are 0, all three pointers are 0 and the stack pointer equals `SP_INIT` (default 0xDF).
- R2: Pointer selector codes are 0 = X, 1 = Y, 2 = Z. Mode codes are 0 = plain, 1 = post-increment, 2 = pre-decrement, 3 = displacement, 4 = direct. In plain mode the selected pointer is the address. In direct mode `req_direct` is the address and the selector is ignored. Neither mode changes any pointer.
- R3: In post-increment mode the address is the selected pointer, and that pointer then increases by 1 (modulo 2^16).
- R4: In pre-decrement mode the selected pointer first decreases by 1 (modulo 2^16), and the new value is the address.
- R5: In displacement mode the address is Y or Z plus the zero-extended 6-bit `req_disp`, and the pointer keeps its value.
- R6: The following requests produce `acc_err` = 1 and `acc_valid` = 0 and leave every pointer unchanged: displacement mode with X, selector 3 in any non-direct mode, and a mode code above 4.
- R7: `acc_region` reports code 0 for addresses 0x00–0x1F (registers), 1 for 0x20–0x5F (I/O), 2 for 0x60–0xDF (SRAM) and 3 for 0xE0 and above (out of range).
- R8: A push issues the current stack pointer as a write address (`acc_write` = 1) and then decrements the stack pointer, wrapping 0x00 to 0xFF.
- R9: A pop first increments the stack pointer, wrapping 0xFF to 0x00, then issues the new value as a read address (`acc_write` = 0).
- R10: Host writes load a pointer or the stack pointer. When a host write and an access update target the same register in the same cycle, the host write wins and the access still uses the old value for its address.
- R11: A data request in the same cycle as a push or pop drops the stack operation. Push and pop together do nothing. A dropped stack operation leaves the stack pointer unchanged.
- R12: Every access result (`acc_addr`, `acc_region`, `acc_write`, `acc_valid`, `acc_err`) and every pointer update appears on the outputs in the cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Data access request |
| req_write | input | 1 | Request is a store |
| req_sel | input | 2 | Pointer selector (0 X, 1 Y, 2 Z) |
| req_mode | input | 3 | Addressing mode code |
| req_disp | input | 6 | Unsigned displacement |
| req_direct | input | 16 | Address for direct mode |
| push | input | 1 | Stack push |
| pop | input | 1 | Stack pop |
| ptr_wr_en | input | 1 | Host pointer write |
| ptr_wr_sel | input | 2 | Pointer to write |
| ptr_wr_data | input | 16 | Pointer write value |
| sp_wr_en | input | 1 | Stack pointer write |
| sp_wr_data | input | 8 | Stack pointer write value |
| acc_valid | output | 1 | Address issued this cycle |
| acc_err | output | 1 | Rejected request |
| acc_write | output | 1 | Issued access is a write |
| acc_addr | output | 16 | Data-space address |
| acc_region | output | 2 | Region code |
| ptr_x | output | 16 | X pointer |
| ptr_y | output | 16 | Y pointer |
| ptr_z | output | 16 | Z pointer, also the constant-read byte address |
| sp | output | 8 | Stack pointer |

## Verification
Each result (address, region, direction flag, error flag and modified pointer or stack pointer) is registered once, so all of them are due exactly one rising edge after the request. The bench drives a request on a falling edge. It drops the request on the next falling edge and compares every output there, half a cycle after the single register stage has updated. For pre-decrement and pop, the bench's expected address is the value after the adjustment. The check then confirms that the address and the updated register show the same value at that sample point.

// File: rtl/dag_pkg.sv
package dag_pkg;
   typedef enum logic [2:0] {
      MD_PLAIN  = 3'd0,
      MD_POSTI  = 3'd1,
      MD_PRED   = 3'd2,
      MD_DISP   = 3'd3,
      MD_DIRECT = 3'd4
   } agu_mode_e;

   typedef enum logic [1:0] {
      RG_REGS = 2'd0,
      RG_IO   = 2'd1,
      RG_SRAM = 2'd2,
      RG_NONE = 2'd3
   } agu_region_e;
endpackage

// File: rtl/dag_ptr_file.sv
module dag_ptr_file #(
   parameter int ADDR_W = 16,
   parameter int N_PTR  = 3,
   parameter int SEL_W  = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          upd_en,
   input  logic [SEL_W-1:0]              upd_sel,
   input  logic [ADDR_W-1:0]             upd_val,
   input  logic                          wr_en,
   input  logic [SEL_W-1:0]              wr_sel,
   input  logic [ADDR_W-1:0]             wr_data,
   output logic [N_PTR-1:0][ADDR_W-1:0]  ptrs
);
   for (genvar i = 0; i < N_PTR; i++) begin : g_ptr
      always_ff @(posedge clk) begin
         if (!rst_n)
            ptrs[i] <= '0;
         else if (wr_en && (wr_sel == SEL_W'(i)))
            ptrs[i] <= wr_data;
         else if (upd_en && (upd_sel == SEL_W'(i)))
            ptrs[i] <= upd_val;
      end
   end
endmodule

// File: rtl/dag_stack.sv
module dag_stack #(
   parameter int          SP_W    = 8,
   parameter logic [7:0]  SP_INIT = 8'hDF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_go,
   input  logic            pop_go,
   input  logic            wr_en,
   input  logic [SP_W-1:0] wr_data,
   output logic [SP_W-1:0] sp,
   output logic [SP_W-1:0] stk_addr
);
   logic [SP_W-1:0] sp_inc;
   assign sp_inc   = sp + SP_W'(1);
   assign stk_addr = pop_go ? sp_inc : sp;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp <= SP_W'(SP_INIT);
      else if (wr_en)
         sp <= wr_data;
      else if (pop_go)
         sp <= sp_inc;
      else if (push_go)
         sp <= sp - SP_W'(1);
   end
endmodule

// File: rtl/dag_region.sv
module dag_region #(
   parameter int ADDR_W = 16,
   parameter int REG_N  = 32,
   parameter int IO_N   = 64,
   parameter int SRAM_N = 128
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [1:0]        region
);
   import dag_pkg::*;
   localparam int IO_BASE   = REG_N;
   localparam int SRAM_BASE = REG_N + IO_N;
   localparam int DATA_TOP  = SRAM_BASE + SRAM_N;

   always_comb begin
      if (addr < ADDR_W'(IO_BASE))
         region = RG_REGS;
      else if (addr < ADDR_W'(SRAM_BASE))
         region = RG_IO;
      else if (addr < ADDR_W'(DATA_TOP))
         region = RG_SRAM;
      else
         region = RG_NONE;
   end
endmodule

// File: rtl/dspace_agu.sv
module dspace_agu #(
   parameter int          ADDR_W    = 16,
   parameter int          SP_W      = 8,
   parameter int          DISP_W    = 6,
   parameter int          REG_N     = 32,
   parameter int          IO_N      = 64,
   parameter int          SRAM_N    = 128,
   parameter logic [7:0]  SP_INIT   = 8'hDF,
   parameter bit          X_DISP_OK = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_sel,
   input  logic [2:0]        req_mode,
   input  logic [DISP_W-1:0] req_disp,
   input  logic [ADDR_W-1:0] req_direct,
   input  logic              push,
   input  logic              pop,
   input  logic              ptr_wr_en,
   input  logic [1:0]        ptr_wr_sel,
   input  logic [ADDR_W-1:0] ptr_wr_data,
   input  logic              sp_wr_en,
   input  logic [SP_W-1:0]   sp_wr_data,
   output logic              acc_valid,
   output logic              acc_err,
   output logic              acc_write,
   output logic [ADDR_W-1:0] acc_addr,
   output logic [1:0]        acc_region,
   output logic [ADDR_W-1:0] ptr_x,
   output logic [ADDR_W-1:0] ptr_y,
   output logic [ADDR_W-1:0] ptr_z,
   output logic [SP_W-1:0]   sp
);
   import dag_pkg::*;
   localparam int N_PTR = 3;
   localparam int SEL_W = 2;

   if (SP_W > ADDR_W) begin : g_chk_sp
      initial $error("stack pointer wider than address");
   end
   if (DISP_W >= ADDR_W) begin : g_chk_disp
      initial $error("displacement not narrower than address");
   end
   if (REG_N + IO_N + SRAM_N > (1 << ADDR_W)) begin : g_chk_map
      initial $error("data map exceeds address space");
   end

   logic [N_PTR-1:0][ADDR_W-1:0] ptrs;
   logic [ADDR_W-1:0] base, eff_addr, upd_val, nxt_addr;
   logic              upd_en, bad, sel_ok, push_go, pop_go, disp_ok;
   logic [SP_W-1:0]   stk_addr;
   logic [1:0]        nxt_region;
   agu_mode_e         mode;

   assign mode = agu_mode_e'(req_mode);

   always_comb begin
      base = '0;
      for (int i = 0; i < N_PTR; i++)
         if (req_sel == SEL_W'(i)) base = ptrs[i];
   end

   assign sel_ok  = (req_sel < SEL_W'(N_PTR));
   assign disp_ok = X_DISP_OK || (req_sel != 2'd0);

   always_comb begin
      bad      = 1'b0;
      upd_en   = 1'b0;
      upd_val  = base;
      eff_addr = base;
      case (mode)
         MD_PLAIN:  bad = !sel_ok;
         MD_POSTI: begin
            bad     = !sel_ok;
            upd_en  = sel_ok;
            upd_val = base + ADDR_W'(1);
         end
         MD_PRED: begin
            bad      = !sel_ok;
            upd_en   = sel_ok;
            upd_val  = base - ADDR_W'(1);
            eff_addr = upd_val;
         end
         MD_DISP: begin
            bad      = !sel_ok || !disp_ok;
            eff_addr = base + {{(ADDR_W-DISP_W){1'b0}}, req_disp};
         end
         MD_DIRECT: eff_addr = req_direct;
         default:   bad = 1'b1;
      endcase
      if (!req_valid) begin
         bad    = 1'b0;
         upd_en = 1'b0;
      end else if (bad) begin
         upd_en = 1'b0;
      end
   end

   assign push_go  = push && !pop && !req_valid;
   assign pop_go   = pop && !push && !req_valid;
   assign nxt_addr = req_valid ? eff_addr : {{(ADDR_W-SP_W){1'b0}}, stk_addr};

   dag_ptr_file #(.ADDR_W(ADDR_W), .N_PTR(N_PTR), .SEL_W(SEL_W)) u_ptrs (
      .clk(clk), .rst_n(rst_n),
      .upd_en(upd_en), .upd_sel(req_sel), .upd_val(upd_val),
      .wr_en(ptr_wr_en), .wr_sel(ptr_wr_sel), .wr_data(ptr_wr_data),
      .ptrs(ptrs)
   );

   dag_stack #(.SP_W(SP_W), .SP_INIT(SP_INIT)) u_stack (
      .clk(clk), .rst_n(rst_n),
      .push_go(push_go), .pop_go(pop_go),
      .wr_en(sp_wr_en), .wr_data(sp_wr_data),
      .sp(sp), .stk_addr(stk_addr)
   );

   dag_region #(.ADDR_W(ADDR_W), .REG_N(REG_N), .IO_N(IO_N), .SRAM_N(SRAM_N)) u_region (
      .addr(nxt_addr), .region(nxt_region)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_valid  <= 1'b0;
         acc_err    <= 1'b0;
         acc_write  <= 1'b0;
         acc_addr   <= '0;
         acc_region <= RG_REGS;
      end else begin
         acc_valid  <= (req_valid && !bad) || push_go || pop_go;
         acc_err    <= bad;
         acc_write  <= req_valid ? req_write : push_go;
         acc_addr   <= nxt_addr;
         acc_region <= nxt_region;
      end
   end

   assign ptr_x = ptrs[0];
   assign ptr_y = ptrs[1];
   assign ptr_z = ptrs[2];
endmodule

// File: rtl/dag_agu_chk.sv
module dag_agu_chk #(
   parameter int ADDR_W = 16,
   parameter int SP_W   = 8,
   parameter int REG_N  = 32,
   parameter int IO_N   = 64,
   parameter int SRAM_N = 128
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [1:0]        req_sel,
   input logic [2:0]        req_mode,
   input logic              push,
   input logic              pop,
   input logic              ptr_wr_en,
   input logic [1:0]        ptr_wr_sel,
   input logic              sp_wr_en,
   input logic              acc_valid,
   input logic              acc_err,
   input logic              acc_write,
   input logic [ADDR_W-1:0] acc_addr,
   input logic [1:0]        acc_region,
   input logic [ADDR_W-1:0] ptr_y,
   input logic [ADDR_W-1:0] ptr_z,
   input logic [SP_W-1:0]   sp
);
   localparam int TOP = REG_N + IO_N + SRAM_N;

   a_r6_err_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
      acc_err |-> !acc_valid);

   a_r3_postinc_y: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd1 && req_sel == 2'd1 && !(ptr_wr_en && ptr_wr_sel == 2'd1))
      |=> (ptr_y == $past(ptr_y) + ADDR_W'(1)) && (acc_addr == $past(ptr_y)));

   a_r4_predec_z: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd2 && req_sel == 2'd2 && !(ptr_wr_en && ptr_wr_sel == 2'd2))
      |=> (ptr_z == $past(ptr_z) - ADDR_W'(1)) && (acc_addr == ptr_z));

   a_r5_disp_keeps_y: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_mode == 3'd3 && req_sel == 2'd1 && !ptr_wr_en) |=> $stable(ptr_y));

   a_r8_push: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop && !req_valid && !sp_wr_en)
      |=> (sp == $past(sp) - SP_W'(1)) && acc_write && acc_valid
          && (acc_addr == ADDR_W'($past(sp))));

   a_r9_pop: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !req_valid && !sp_wr_en)
      |=> (sp == $past(sp) + SP_W'(1)) && !acc_write && (acc_addr == ADDR_W'(sp)));

   a_r11_stack_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (push || pop) && !sp_wr_en) |=> $stable(sp));

   a_r7_low_regs: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr < ADDR_W'(REG_N)) |-> acc_region == 2'd0);

   a_r7_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_addr >= ADDR_W'(TOP)) |-> acc_region == 2'd3);
endmodule

bind dspace_agu dag_agu_chk #(
   .ADDR_W(ADDR_W), .SP_W(SP_W), .REG_N(REG_N), .IO_N(IO_N), .SRAM_N(SRAM_N)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
   .req_mode(req_mode), .push(push), .pop(pop), .ptr_wr_en(ptr_wr_en),
   .ptr_wr_sel(ptr_wr_sel), .sp_wr_en(sp_wr_en), .acc_valid(acc_valid),
   .acc_err(acc_err), .acc_write(acc_write), .acc_addr(acc_addr),
   .acc_region(acc_region), .ptr_y(ptr_y), .ptr_z(ptr_z), .sp(sp)
);

// File: tb/test_dspace_agu.sv
module test_dspace_agu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 0, req_write = 0, push = 0, pop = 0;
   logic [1:0]  req_sel = 0, ptr_wr_sel = 0;
   logic [2:0]  req_mode = 0;
   logic [5:0]  req_disp = 0;
   logic [15:0] req_direct = 0, ptr_wr_data = 0;
   logic        ptr_wr_en = 0, sp_wr_en = 0;
   logic [7:0]  sp_wr_data = 0;
   logic        acc_valid, acc_err, acc_write;
   logic [15:0] acc_addr, ptr_x, ptr_y, ptr_z;
   logic [1:0]  acc_region;
   logic [7:0]  sp;

   int total = 0, bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   dspace_agu i_dspace_agu (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_sel(req_sel), .req_mode(req_mode), .req_disp(req_disp),
      .req_direct(req_direct), .push(push), .pop(pop), .ptr_wr_en(ptr_wr_en),
      .ptr_wr_sel(ptr_wr_sel), .ptr_wr_data(ptr_wr_data), .sp_wr_en(sp_wr_en),
      .sp_wr_data(sp_wr_data), .acc_valid(acc_valid), .acc_err(acc_err),
      .acc_write(acc_write), .acc_addr(acc_addr), .acc_region(acc_region),
      .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z), .sp(sp)
   );

   // entry: sel[44:43] mode[42:40] disp[39:34] addr[33:18] region[17:16] ptr[15:0]
   localparam logic [44:0] VEC [10] = '{
      {2'd0, 3'd0, 6'd0,  16'h0040, 2'd1, 16'h0040},  // R2 X plain
      {2'd0, 3'd1, 6'd0,  16'h0040, 2'd1, 16'h0041},  // R3 X post-inc
      {2'd0, 3'd2, 6'd0,  16'h0040, 2'd1, 16'h0040},  // R4 X pre-dec
      {2'd1, 3'd3, 6'd5,  16'h0065, 2'd2, 16'h0060},  // R5 Y disp
      {2'd1, 3'd2, 6'd0,  16'h005F, 2'd1, 16'h005F},  // R4 Y pre-dec
      {2'd2, 3'd1, 6'd0,  16'h00DF, 2'd2, 16'h00E0},  // R3 Z post-inc
      {2'd2, 3'd0, 6'd0,  16'h00E0, 2'd3, 16'h00E0},  // R7 Z plain out of range
      {2'd2, 3'd3, 6'd63, 16'h011F, 2'd3, 16'h00E0},  // R5 Z max disp
      {2'd2, 3'd2, 6'd0,  16'h00DF, 2'd2, 16'h00DF},  // R4 Z pre-dec
      {2'd0, 3'd2, 6'd0,  16'h003F, 2'd1, 16'h003F}   // R4 X pre-dec
   };

   task automatic check(string req, string what, int got, int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, got, exp);
      end
   endtask

   task automatic drive(input logic v, input logic w, input logic [1:0] s,
                        input logic [2:0] m, input logic [5:0] d, input logic [15:0] dir,
                        input logic ps, input logic pp, input logic pwe,
                        input logic [1:0] psel, input logic [15:0] pdat,
                        input logic swe, input logic [7:0] sdat);
      @(negedge clk);
      req_valid = v; req_write = w; req_sel = s; req_mode = m; req_disp = d;
      req_direct = dir; push = ps; pop = pp; ptr_wr_en = pwe; ptr_wr_sel = psel;
      ptr_wr_data = pdat; sp_wr_en = swe; sp_wr_data = sdat;
      @(negedge clk);
      req_valid = 0; push = 0; pop = 0; ptr_wr_en = 0; sp_wr_en = 0;
   endtask

   task automatic direct_chk(input logic [15:0] a, input logic [1:0] rg);
      drive(1, 0, 2'd3, 3'd4, 0, a, 0, 0, 0, 0, 0, 0, 0);
      check("R7", "direct region", acc_region, rg);
      check("R2", "direct addr", acc_addr, a);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1", "valid in reset", acc_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "valid", acc_valid, 0);
      check("R1", "err", acc_err, 0);
      check("R1", "sp", sp, 8'hDF);
      check("R1", "ptrs", {ptr_x, ptr_y, ptr_z} == 48'd0, 1);

      // R10 host loads
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd0, 16'h0040, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 16'h0060, 0, 0);
      drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 16'h00DF, 0, 0);
      check("R10", "x load", ptr_x, 16'h0040);
      check("R10", "z load", ptr_z, 16'h00DF);

      for (int i = 0; i < 10; i++) begin
         logic [44:0] e;
         int p;
         e = VEC[i];
         drive(1, i[0], e[44:43], e[42:40], e[39:34], 0, 0, 0, 0, 0, 0, 0, 0);
         p = (e[44:43] == 2'd0) ? ptr_x : (e[44:43] == 2'd1) ? ptr_y : ptr_z;
         check("R12", "valid", acc_valid, 1);
         check("R12", "write flag", acc_write, i[0]);
         check("R2", "vec addr", acc_addr, e[33:18]);
         check("R7", "vec region", acc_region, e[17:16]);
         check("R3", "vec ptr", p, e[15:0]);
      end

      // R7 boundaries through direct mode
      direct_chk(16'h001F, 2'd0);
      direct_chk(16'h0020, 2'd1);
      direct_chk(16'h005F, 2'd1);
      direct_chk(16'h0060, 2'd2);
      direct_chk(16'h00DF, 2'd2);
      direct_chk(16'h00E0, 2'd3);
      check("R2", "direct keeps x", ptr_x, 16'h003F);

      // R6 rejects
      drive(1, 0, 2'd0, 3'd3, 6'd4, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R6", "x disp err", acc_err, 1);
      check("R6", "x disp valid", acc_valid, 0);
      check("R6", "x disp ptr", ptr_x, 16'h003F);
      drive(1, 0, 2'd3, 3'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R6", "sel3 err", acc_err, 1);
      drive(1, 0, 2'd1, 3'd6, 0, 0, 0, 0, 0, 0, 0, 0, 0);
      check("R6", "mode6 err", acc_err, 1);
      check("R6", "mode6 y", ptr_y, 16'h005F);

      // R8 / R9 stack
      drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
      check("R8", "push addr", acc_addr, 16'h00DF);
      check("R8", "push write", acc_write, 1);
      check("R8", "push sp", sp, 8'hDE);
      drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      check("R9", "pop addr", acc_addr, 16'h00DF);
      check("R9", "pop write", acc_write, 0);
      check("R9", "pop sp", sp, 8'hDF);

      // R11 request beats stack op; push+pop together
      drive(1, 1, 2'd1, 3'd0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
      check("R11", "req addr", acc_addr, 16'h005F);
      check("R11", "sp kept", sp, 8'hDF);
      drive(0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
      check("R11", "both valid", acc_valid, 0);
      check("R11", "both sp", sp, 8'hDF);

      // R10 host write wins over same-cycle update
      drive(1, 0, 2'd1, 3'd1, 0, 0, 0, 0, 1, 2'd1, 16'h1234, 0, 0);
      check("R10", "old addr", acc_addr, 16'h005F);
      check("R10", "host wins", ptr_y, 16'h1234);

      // R8/R9 wrap
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h00);
      check("R10", "sp load", sp, 8'h00);
      drive(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0);
      check("R8", "wrap addr", acc_addr, 16'h0000);
      check("R7", "wrap region", acc_region, 2'd0);
      check("R8", "wrap sp", sp, 8'hFF);
      drive(0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
      check("R9", "wrap pop addr", acc_addr, 16'h0000);
      check("R9", "wrap pop sp", sp, 8'h00);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule